// File: doc/BRIEF.md
# Context Sequencing Controller

This block steps a reconfigurable processing array through the contexts of one task. Each context is a complete hardware configuration of the array. While a task runs, the controller sends one context number per clock to every processing element. From a transition table and the condition flags that the array returns, it picks the context for the following clock. A task starts at context 0 and ends when the controller leaves a context marked as final. The controller then pulses a completion strobe and waits for the next start.

The transition table has two banks. The task reads the active bank. A host writes the table for the next task into the inactive bank at any time, including while the current task runs. The host then raises a load-complete strobe. The controller swaps the banks at the first clock it spends idle, so the next task can start with no reload gap.

Values computed combinationally inside the array exist only in the context that produces them. The compiler must place anything needed later into registers. The controller only sequences.

Top module: `ctx_seq_ctrl`

## Requirements
- R1: After reset the controller is idle, `ctx_o` is 0, `done_o` and `swap_o` are 0, and bank 0 is the active bank.
- R2: A `start_i` sampled while idle starts a task. From the next clock `ctx_o` is 0 and the controller is running.
- R3: While running, each clock moves to one new context. An entry's flag index selects one bit of `flags_i`. If that bit is 1 the next context is the alternate field, otherwise it is the default field.
- R4: A clock spent in a context whose final bit is set ends the task. After it, `done_o` is high for exactly one cycle, the controller is idle, and `ctx_o` keeps the final context number.
- R5: While idle, `ctx_o` holds its value and changes on `flags_i` have no effect. A `start_i` while running has no effect.
- R6: `tbl_we_i` writes `tbl_wdata_i` at `tbl_addr_i` into the bank that is inactive at that clock. The running task is not affected.
- R7: A `load_done_i` pulse causes a swap of the active bank at the first clock edge at which the controller is idle, deferred if it arrives while running. `swap_o` is high for one cycle after each swap.
- R8: A table entry is 12 bits: bit 11 is the final bit, bits 10:8 the flag index, bits 7:4 the alternate next context, and bits 3:0 the default next context.
- R9: All 16 context numbers 0 to 15 can be reached and driven on `ctx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a task (honoured only when idle) |
| flags_i | input | 8 | Condition flags returned by the array |
| tbl_we_i | input | 1 | Table write enable (inactive bank) |
| tbl_addr_i | input | 4 | Context whose entry is written |
| tbl_wdata_i | input | 12 | Entry value, layout per R8 |
| load_done_i | input | 1 | Next table is complete; request a bank swap |
| ctx_o | output | 4 | Context number broadcast to the array |
| done_o | output | 1 | One-cycle pulse at end of task |
| swap_o | output | 1 | One-cycle pulse after a bank swap |

## Verification
The bench writes a new table into the inactive bank while a task runs. A design that wrote into the active bank would derail the running sequence. It raises load-complete in the final context of a task. A design that swapped while running would show `swap_o` one cycle early. It drives flag patterns that take branch, fall-through and a loop through context 15. A design with the flag polarity or the index wrong would follow the wrong path. It also toggles flags and start where both must be ignored. A design that did not hold its state would move `ctx_o` or restart the task.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ctx_tbl_bank.sv
module ctx_tbl_bank #(
  parameter int CTX_W   = 4,
  parameter int ENT_W   = 12,
  parameter int NUM_CTX = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wbank,
  input  logic [CTX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic             rbank,
  input  logic [CTX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ENT_W-1:0] mem [NUM_CTX];
    logic             bank_we;

    assign bank_we = we && (wbank == b[0]);

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[waddr] <= wdata;
      end
    end

    assign bank_rd[b] = mem[raddr];
  end

  assign rdata = rbank ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/ctx_next_sel.sv
module ctx_next_sel #(
  parameter int CTX_W     = 4,
  parameter int NUM_FLAGS = 8,
  parameter int FLAG_W    = 3,
  parameter int ENT_W     = 12
) (
  input  logic [ENT_W-1:0]     entry,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [CTX_W-1:0]     next_ctx,
  output logic                 is_last
);
  localparam int DFLT_LSB = 0;
  localparam int ALT_LSB  = CTX_W;
  localparam int IDX_LSB  = 2 * CTX_W;
  localparam int LAST_BIT = 2 * CTX_W + FLAG_W;

  logic [FLAG_W-1:0] sel_idx;
  logic              cond;

  always_comb begin
    sel_idx  = entry[IDX_LSB +: FLAG_W];
    cond     = flags[sel_idx];
    is_last  = entry[LAST_BIT];
    next_ctx = cond ? entry[ALT_LSB +: CTX_W] : entry[DFLT_LSB +: CTX_W];
  end
endmodule

// File: rtl/ctx_bank_ctrl.sv
module ctx_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load_done,
  input  logic idle,
  output logic bank_sel,
  output logic swap
);
  logic pend_q, pend_d;
  logic bank_d;
  logic do_swap;

  always_comb begin
    do_swap = idle && (pend_q || load_done);
    pend_d  = (pend_q || load_done) && !do_swap;
    bank_d  = do_swap ? !bank_sel : bank_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      bank_sel <= 1'b0;
      swap     <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      bank_sel <= bank_d;
      swap     <= do_swap;
    end
  end
endmodule

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl #(
  parameter int NUM_CTX   = 16,
  parameter int NUM_FLAGS = 8,
  parameter int CTX_W     = $clog2(NUM_CTX),
  parameter int FLAG_W    = $clog2(NUM_FLAGS),
  parameter int ENT_W     = 1 + FLAG_W + 2 * CTX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 tbl_we_i,
  input  logic [CTX_W-1:0]     tbl_addr_i,
  input  logic [ENT_W-1:0]     tbl_wdata_i,
  input  logic                 load_done_i,
  output logic [CTX_W-1:0]     ctx_o,
  output logic                 done_o,
  output logic                 swap_o
);
  import ctx_seq_pkg::*;

  seq_state_e       state_q, state_d;
  logic [CTX_W-1:0] ctx_q, ctx_d;
  logic             done_d;
  logic             busy;
  logic             bank_sel;
  logic [ENT_W-1:0] cur_entry;
  logic [CTX_W-1:0] sel_ctx;
  logic             sel_last;

  assign busy = (state_q == ST_RUN);

  ctx_tbl_bank #(.CTX_W(CTX_W), .ENT_W(ENT_W), .NUM_CTX(NUM_CTX)) u_tbl (
    .clk   (clk),
    .we    (tbl_we_i),
    .wbank (!bank_sel),
    .waddr (tbl_addr_i),
    .wdata (tbl_wdata_i),
    .rbank (bank_sel),
    .raddr (ctx_q),
    .rdata (cur_entry)
  );

  ctx_next_sel #(.CTX_W(CTX_W), .NUM_FLAGS(NUM_FLAGS), .FLAG_W(FLAG_W),
                 .ENT_W(ENT_W)) u_sel (
    .entry    (cur_entry),
    .flags    (flags_i),
    .next_ctx (sel_ctx),
    .is_last  (sel_last)
  );

  ctx_bank_ctrl u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_done (load_done_i),
    .idle      (!busy),
    .bank_sel  (bank_sel),
    .swap      (swap_o)
  );

  always_comb begin
    state_d = state_q;
    ctx_d   = ctx_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          ctx_d   = '0;
        end
      end
      ST_RUN: begin
        if (sel_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          ctx_d = sel_ctx;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctx_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      ctx_q   <= ctx_d;
      done_o  <= done_d;
    end
  end

  assign ctx_o = ctx_q;
endmodule

// File: rtl/ctx_seq_chk.sv
module ctx_seq_chk #(
  parameter int CTX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy,
  input logic [CTX_W-1:0] ctx_o,
  input logic             done_o,
  input logic             swap_o
);
  a_r2_start_ctx0: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (busy && ctx_o == '0));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(ctx_o));

  a_r7_swap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> !$past(busy));
endmodule

bind ctx_seq_ctrl ctx_seq_chk #(.CTX_W(CTX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy    (busy),
  .ctx_o   (ctx_o),
  .done_o  (done_o),
  .swap_o  (swap_o)
);

// File: tb/ctx_seq_ctrl_bench.sv
module ctx_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  flags_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_addr_i = '0;
  logic [11:0] tbl_wdata_i = '0;
  logic        load_done_i = 1'b0;
  logic [3:0]  ctx_o;
  logic        done_o;
  logic        swap_o;

  int n_chk = 0;
  int n_fail = 0;
  bit seen15 = 0;

  ctx_seq_ctrl u_ctx_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .flags_i(flags_i),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_wdata_i(tbl_wdata_i),
    .load_done_i(load_done_i), .ctx_o(ctx_o), .done_o(done_o), .swap_o(swap_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int m_tbl [2][16];
  int m_bank, m_ctx;
  bit m_run, m_done, m_swap, m_pend;

  function automatic logic [11:0] ent(bit last, int idx, int alt, int dflt);
    return {last, idx[2:0], alt[3:0], dflt[3:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bank = 0; m_ctx = 0; m_run = 0; m_done = 0; m_swap = 0; m_pend = 0;
    end else begin
      int  e;
      bit  old_run;
      bit  swap_now;
      int  old_bank;
      old_run  = m_run;
      old_bank = m_bank;
      m_done   = 0;
      if (old_run) begin
        e = m_tbl[old_bank][m_ctx];
        if ((e >> 11) & 1) begin
          m_run  = 0;
          m_done = 1;
        end else if (flags_i[(e >> 8) & 7]) begin
          m_ctx = (e >> 4) & 15;
        end else begin
          m_ctx = e & 15;
        end
      end else if (start_i) begin
        m_run = 1;
        m_ctx = 0;
      end
      if (tbl_we_i) m_tbl[1 - old_bank][tbl_addr_i] = tbl_wdata_i;
      swap_now = !old_run && (m_pend || load_done_i);
      m_pend   = (m_pend || load_done_i) && !swap_now;
      if (swap_now) m_bank = 1 - old_bank;
      m_swap = swap_now;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ctx_o == m_ctx[3:0], "R3 ctx_o", ctx_o, m_ctx);
      chk(done_o == m_done, "R4 done_o", done_o, m_done);
      chk(swap_o == m_swap, "R7 swap_o", swap_o, m_swap);
      if (ctx_o == 4'd15) seen15 = 1;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int addr, logic [11:0] d);
    tbl_we_i = 1'b1; tbl_addr_i = addr[3:0]; tbl_wdata_i = d;
    cyc();
    tbl_we_i = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) m_tbl[b][i] = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc();
    chk(ctx_o == 0, "R1 reset ctx", ctx_o, 0);
    chk(done_o == 0 && swap_o == 0, "R1 reset strobes", {done_o, swap_o}, 0);

    // Linear table into bank 1 (R8 layout)
    wr(0, ent(0, 0, 0, 1));
    wr(1, ent(0, 0, 0, 2));
    wr(2, ent(0, 0, 0, 3));
    wr(3, ent(1, 0, 0, 0));
    load_done_i = 1'b1; cyc(); load_done_i = 1'b0;
    chk(swap_o == 1, "R7 idle swap pulse", swap_o, 1);
    cyc();
    chk(swap_o == 0, "R7 swap one cycle", swap_o, 0);

    // Run task A while writing branch table into bank 0 (R6), load_done deferred
    start_i = 1'b1;
    tbl_we_i = 1'b1; tbl_addr_i = 0; tbl_wdata_i = ent(0, 2, 5, 1);
    cyc(); start_i = 1'b0;
    chk(ctx_o == 0, "R2 start to ctx0", ctx_o, 0);
    tbl_addr_i = 1; tbl_wdata_i = ent(1, 0, 0, 0);
    cyc();
    chk(ctx_o == 1, "R6 task unaffected by write", ctx_o, 1);
    tbl_addr_i = 5; tbl_wdata_i = ent(0, 7, 15, 6);
    cyc();
    tbl_addr_i = 6; tbl_wdata_i = ent(1, 0, 0, 0);
    cyc();
    chk(ctx_o == 3, "R6 task reaches ctx3", ctx_o, 3);
    tbl_addr_i = 15; tbl_wdata_i = ent(0, 3, 0, 6);
    load_done_i = 1'b1;
    cyc();
    tbl_we_i = 1'b0; load_done_i = 1'b0;
    chk(done_o == 1, "R4 done pulse", done_o, 1);
    chk(swap_o == 0, "R7 swap deferred while running", swap_o, 0);
    chk(ctx_o == 3, "R4 ctx holds final", ctx_o, 3);
    cyc();
    chk(done_o == 0, "R4 done one cycle", done_o, 0);
    chk(swap_o == 1, "R7 swap once idle", swap_o, 1);

    // R5: flags ignored while idle
    for (int i = 0; i < 6; i++) begin
      flags_i = 8'(i * 37 + 5);
      cyc();
      chk(ctx_o == 3, "R5 idle ctx hold", ctx_o, 3);
    end

    // Branch taken: flag2=1 -> 5, flag7=0 -> 6, final
    flags_i = 8'b0000_0100;
    start_i = 1'b1; cyc(); start_i = 1'b0;
    cyc();
    chk(ctx_o == 5, "R3 alternate taken", ctx_o, 5);
    start_i = 1'b1; cyc(); start_i = 1'b0;
    chk(ctx_o == 6, "R5 start while running ignored", ctx_o, 6);
    cyc(3);

    // Fall-through: flag2=0 -> 1, final
    flags_i = 8'b1111_1011;
    start_i = 1'b1; cyc(); start_i = 1'b0;
    cyc();
    chk(ctx_o == 1, "R3 default taken", ctx_o, 1);
    cyc(3);

    // Loop 0 -> 5 -> 15 -> 0 ..., exit via 6
    flags_i = 8'b1000_1100;
    start_i = 1'b1; cyc(); start_i = 1'b0;
    cyc(2);
    chk(ctx_o == 15, "R9 ctx15 reached", ctx_o, 15);
    cyc(5);
    flags_i = 8'b1000_0100;
    cyc(6);
    chk(seen15 == 1, "R9 ctx15 seen", seen15, 1);
    chk(ctx_o == 6, "R4 loop exit final ctx", ctx_o, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule